// File: doc/BRIEF.md
# ECC Engine Register Front End

This block is the register-side shell around an error-correcting engine that protects NAND page chunks. Software arms the engine through a control register that cannot be written directly. A write to the set alias ORs bits in, and a write to the clear alias removes them. Software then programs how many bytes make up the chunk and feeds those bytes one per write into a data port. The front end counts the accepted bytes and forwards each one to the engine side. When the programmed count is reached it raises an encode-done or decode-done flag.

While the bytes stream in, the block watches whether every byte was 0xFF (erased page) or every byte was 0x00. It reports either case next to the done flag, so software can skip correction on blank chunks. The engine itself is outside this block. A simple result port lets the engine deposit parity bytes, error-index words, an error count, a total error field and an uncorrectable flag. Software then reads these back over the register bus.

Status bits are cleared by writing ones. A single interrupt line is the OR of the status bits that the interrupt-enable register selects.

Top module: `ecc_regfront`

## Requirements
- R1: The control register (offset 0x00, read-only) changes only on a write to offset 0x04, which ORs the write data into it, or on a write to offset 0x08, which clears the bits set in the write data. The init bit's self-clear is the only other change. Control bits: bit 0 engine enable, bit 1 init, bit 2 strong (8-bit) correction, bit 3 encode when one and decode when zero. A write to offset 0x00 has no effect.
- R2: Setting the init bit drives `eng_init` high for exactly one cycle. The bit then reads back as zero. The init resets the byte counter and the all-0xFF and all-0x00 trackers.
- R3: The count register at offset 0x0C keeps the encode byte count in bits [9:0] and the decode byte count in bits [25:16]. All other bits read as zero.
- R4: A write to the data port (offset 0x10) is accepted only while the enable bit is one, the init bit is zero and fewer bytes than the active count have been accepted. Each accepted byte appears on `eng_byte` with `eng_byte_vld` high in the cycle after the write. Refused writes produce no strobe.
- R5: The active count is the encode count in encode mode and the decode count in decode mode. The decode count covers data plus parity bytes. The write that reaches the count sets status bit 2 in encode mode or status bit 3 in decode mode. Later writes are ignored, and a count of zero accepts nothing.
- R6: With the done flag, status bit 4 is set if every accepted byte since the last init was 0xFF, and status bit 5 is set if every one was 0x00.
- R7: The status register (offset 0x24) is write-one-to-clear on every bit. Writing back a value read clears exactly the bits that were one, and other bits are kept.
- R8: An engine result pulse sets status bit 1 when uncorrectable and sets bit 0 when uncorrectable or when the error count is non-zero. The same pulse ORs the error count into bits [31:28] and the total error field into bits [22:16].
- R9: Parity captured from the engine reads as little-endian 32-bit words from offset 0x14. Byte n sits in word n/4 at bit 8*(n%4). Bytes past the parity length read as zero.
- R10: The interrupt enable register (offset 0x38, bits [5:0]) is set through offset 0x3C and cleared through offset 0x40. `irq` is high exactly while some status bit in [5:0] is set and enabled.
- R11: The error-index words captured from the engine read back unchanged at offset 0x28 plus 4 times the word number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked status interrupt |
| eng_en | output | 1 | Engine enable (control bit 0) |
| eng_init | output | 1 | One-cycle init pulse (control bit 1) |
| eng_strong | output | 1 | Strong correction mode (control bit 2) |
| eng_enc | output | 1 | Encode mode (control bit 3) |
| eng_byte_vld | output | 1 | Accepted byte strobe |
| eng_byte | output | 8 | Accepted byte value |
| eng_res_vld | input | 1 | Engine result capture pulse |
| eng_uncor | input | 1 | Result is uncorrectable |
| eng_err_cnt | input | ERRC_W | Number of correctable errors |
| eng_err_tot | input | TERR_W | Total error field |
| eng_parity | input | PAR_BYTES*8 | Parity bytes, byte n in bits [8n+7:8n] |
| eng_err_idx | input | IDX_WORDS*32 | Error-index words |

## Verification
The byte path is tried with four kinds of block:
- Distinct bytes in encode mode check that the encode count is the one in force.
- All-0xFF and all-0x00 decode blocks show that each blank flag is set only by its own pattern.
- A mixed decode block shows that neither flag leaks.
- Extra writes after the count, writes while disabled and a zero count show that the counter's gating has no leak.

Engine results with different error counts and with the uncorrectable flag show how the fields accumulate. Partial write-one-to-clear writes show that status bits are cleared one at a time.

// File: rtl/ecc_regfront_pkg.sv
package ecc_regfront_pkg;
   localparam int unsigned AW = 7;
   localparam int unsigned DW = 32;

   localparam logic [AW-1:0] OFS_CTRL  = 7'h00;
   localparam logic [AW-1:0] OFS_CSET  = 7'h04;
   localparam logic [AW-1:0] OFS_CCLR  = 7'h08;
   localparam logic [AW-1:0] OFS_CNT   = 7'h0C;
   localparam logic [AW-1:0] OFS_DATA  = 7'h10;
   localparam logic [AW-1:0] OFS_PAR   = 7'h14;
   localparam logic [AW-1:0] OFS_STAT  = 7'h24;
   localparam logic [AW-1:0] OFS_IDX   = 7'h28;
   localparam logic [AW-1:0] OFS_IE    = 7'h38;
   localparam logic [AW-1:0] OFS_IESET = 7'h3C;
   localparam logic [AW-1:0] OFS_IECLR = 7'h40;

   // control bit positions
   localparam int unsigned CB_EN     = 0;
   localparam int unsigned CB_INIT   = 1;
   localparam int unsigned CB_STRONG = 2;
   localparam int unsigned CB_ENC    = 3;
   localparam int unsigned CTRL_W    = 4;

   // status bit positions
   localparam int unsigned SB_ERR  = 0;
   localparam int unsigned SB_UNC  = 1;
   localparam int unsigned SB_ENCD = 2;
   localparam int unsigned SB_DECD = 3;
   localparam int unsigned SB_AFF  = 4;
   localparam int unsigned SB_A00  = 5;
   localparam int unsigned IE_W    = 6;
   localparam int unsigned SF_TERR = 16;
   localparam int unsigned SF_ERRC = 28;
   localparam int unsigned CNT_DEC_LSB = 16;
endpackage

// File: rtl/ecc_sc_reg.sv
module ecc_sc_reg #(
   parameter int unsigned     W        = 4,
   parameter logic [W-1:0]    AUTO_CLR = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic [W-1:0] set_m, clr_m;

   assign set_m = set_we ? din : '0;
   assign clr_m = clr_we ? din : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= ((q & ~AUTO_CLR) | set_m) & ~clr_m;
   end
endmodule

// File: rtl/ecc_byte_feed.sv
module ecc_byte_feed #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             en,
   input  logic             enc,
   input  logic             wr_byte,
   input  logic [7:0]       byte_in,
   input  logic [CNT_W-1:0] enc_tgt,
   input  logic [CNT_W-1:0] dec_tgt,
   output logic             byte_vld_o,
   output logic [7:0]       byte_o,
   output logic             done_o,
   output logic             all_ff_o,
   output logic             all_00_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_nxt, tgt;
   logic             aff_q, a00_q, acc, ff_now, z_now;

   assign tgt     = enc ? enc_tgt : dec_tgt;
   assign acc     = wr_byte && en && !init && (cnt_q < tgt);
   assign cnt_nxt = cnt_q + ONE;
   assign ff_now  = aff_q && (byte_in == 8'hFF);
   assign z_now   = a00_q && (byte_in == 8'h00);

   assign done_o   = acc && (cnt_nxt == tgt);
   assign all_ff_o = done_o && ff_now;
   assign all_00_o = done_o && z_now;
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         aff_q      <= 1'b1;
         a00_q      <= 1'b1;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
      end else begin
         byte_vld_o <= acc;
         if (acc) byte_o <= byte_in;
         if (init) begin
            cnt_q <= '0;
            aff_q <= 1'b1;
            a00_q <= 1'b1;
         end else if (acc) begin
            cnt_q <= cnt_nxt;
            aff_q <= ff_now;
            a00_q <= z_now;
         end
      end
   end
endmodule

// File: rtl/ecc_stat_reg.sv
module ecc_stat_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic         w1c_we,
   input  logic [W-1:0] w1c_v,
   output logic [W-1:0] q
);
   logic [W-1:0] clr_m;

   assign clr_m = w1c_we ? w1c_v : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_m) | set_v;
   end
endmodule

// File: rtl/ecc_result_store.sv
module ecc_result_store #(
   parameter int unsigned PAR_BYTES = 13,
   parameter int unsigned IDX_WORDS = 4,
   localparam int unsigned PAR_WORDS = (PAR_BYTES + 3) / 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap,
   input  logic [PAR_BYTES*8-1:0]  par_in,
   input  logic [IDX_WORDS*32-1:0] idx_in,
   output logic [PAR_WORDS*32-1:0] par_words_o,
   output logic [IDX_WORDS*32-1:0] idx_o
);
   logic [PAR_BYTES*8-1:0]  par_q;
   logic [IDX_WORDS*32-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_q <= '0;
         idx_q <= '0;
      end else if (cap) begin
         par_q <= par_in;
         idx_q <= idx_in;
      end
   end

   for (genvar w = 0; w < PAR_WORDS; w++) begin : g_pw
      for (genvar b = 0; b < 4; b++) begin : g_pb
         if (w * 4 + b < PAR_BYTES) begin : g_live
            assign par_words_o[w*32+b*8 +: 8] = par_q[(w*4+b)*8 +: 8];
         end else begin : g_pad
            assign par_words_o[w*32+b*8 +: 8] = 8'h00;
         end
      end
   end

   assign idx_o = idx_q;
endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
   import ecc_regfront_pkg::*;
#(
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned PAR_BYTES = 13,
   parameter int unsigned IDX_WORDS = 4,
   parameter int unsigned ERRC_W    = 4,
   parameter int unsigned TERR_W    = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [6:0]              bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   output logic                    irq,
   output logic                    eng_en,
   output logic                    eng_init,
   output logic                    eng_strong,
   output logic                    eng_enc,
   output logic                    eng_byte_vld,
   output logic [7:0]              eng_byte,
   input  logic                    eng_res_vld,
   input  logic                    eng_uncor,
   input  logic [ERRC_W-1:0]       eng_err_cnt,
   input  logic [TERR_W-1:0]       eng_err_tot,
   input  logic [PAR_BYTES*8-1:0]  eng_parity,
   input  logic [IDX_WORDS*32-1:0] eng_err_idx
);
   localparam int unsigned PAR_WORDS = (PAR_BYTES + 3) / 4;
   localparam logic [CTRL_W-1:0] INIT_MASK = CTRL_W'(1) << CB_INIT;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end
   if (PAR_BYTES < 1 || PAR_WORDS > 4) begin : g_bad_par
      $error("parity must fit in four words");
   end
   if (IDX_WORDS < 1 || IDX_WORDS > 4) begin : g_bad_idx
      $error("IDX_WORDS must lie in 1..4");
   end
   if (ERRC_W < 1 || ERRC_W > 4 || TERR_W < 1 || TERR_W > 7) begin : g_bad_fld
      $error("status field width out of range");
   end

   logic [CTRL_W-1:0]          ctrl_q;
   logic [IE_W-1:0]            ie_q;
   logic [31:0]                stat_q, stat_set;
   logic [CNT_W-1:0]           enc_tgt_q, dec_tgt_q, byte_cnt;
   logic                       done, all_ff, all_00;
   logic [PAR_WORDS*32-1:0]    par_words;
   logic [IDX_WORDS*32-1:0]    idx_words;

   logic wr_cset, wr_cclr, wr_cnt, wr_data, wr_stat, wr_ieset, wr_ieclr;
   assign wr_cset  = bus_wr && (bus_addr == OFS_CSET);
   assign wr_cclr  = bus_wr && (bus_addr == OFS_CCLR);
   assign wr_cnt   = bus_wr && (bus_addr == OFS_CNT);
   assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
   assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
   assign wr_ieset = bus_wr && (bus_addr == OFS_IESET);
   assign wr_ieclr = bus_wr && (bus_addr == OFS_IECLR);

   ecc_sc_reg #(.W(CTRL_W), .AUTO_CLR(INIT_MASK)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .set_we(wr_cset), .clr_we(wr_cclr),
      .din(bus_wdata[CTRL_W-1:0]), .q(ctrl_q)
   );

   ecc_sc_reg #(.W(IE_W), .AUTO_CLR('0)) u_ie (
      .clk(clk), .rst_n(rst_n), .set_we(wr_ieset), .clr_we(wr_ieclr),
      .din(bus_wdata[IE_W-1:0]), .q(ie_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enc_tgt_q <= '0;
         dec_tgt_q <= '0;
      end else if (wr_cnt) begin
         enc_tgt_q <= bus_wdata[CNT_W-1:0];
         dec_tgt_q <= bus_wdata[CNT_DEC_LSB +: CNT_W];
      end
   end

   ecc_byte_feed #(.CNT_W(CNT_W)) u_feed (
      .clk(clk), .rst_n(rst_n),
      .init(ctrl_q[CB_INIT]), .en(ctrl_q[CB_EN]), .enc(ctrl_q[CB_ENC]),
      .wr_byte(wr_data), .byte_in(bus_wdata[7:0]),
      .enc_tgt(enc_tgt_q), .dec_tgt(dec_tgt_q),
      .byte_vld_o(eng_byte_vld), .byte_o(eng_byte),
      .done_o(done), .all_ff_o(all_ff), .all_00_o(all_00), .cnt_o(byte_cnt)
   );

   always_comb begin
      stat_set          = '0;
      stat_set[SB_ENCD] = done && ctrl_q[CB_ENC];
      stat_set[SB_DECD] = done && !ctrl_q[CB_ENC];
      stat_set[SB_AFF]  = all_ff;
      stat_set[SB_A00]  = all_00;
      if (eng_res_vld) begin
         stat_set[SB_UNC]            = eng_uncor;
         stat_set[SB_ERR]            = eng_uncor || (eng_err_cnt != '0);
         stat_set[SF_ERRC +: ERRC_W] = eng_err_cnt;
         stat_set[SF_TERR +: TERR_W] = eng_err_tot;
      end
   end

   ecc_stat_reg #(.W(32)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_v(stat_set),
      .w1c_we(wr_stat), .w1c_v(bus_wdata), .q(stat_q)
   );

   ecc_result_store #(.PAR_BYTES(PAR_BYTES), .IDX_WORDS(IDX_WORDS)) u_res (
      .clk(clk), .rst_n(rst_n), .cap(eng_res_vld),
      .par_in(eng_parity), .idx_in(eng_err_idx),
      .par_words_o(par_words), .idx_o(idx_words)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
         OFS_CNT: begin
            bus_rdata[CNT_W-1:0]             = enc_tgt_q;
            bus_rdata[CNT_DEC_LSB +: CNT_W]  = dec_tgt_q;
         end
         OFS_STAT: bus_rdata = stat_q;
         OFS_IE:   bus_rdata[IE_W-1:0] = ie_q;
         default:  bus_rdata = '0;
      endcase
      for (int i = 0; i < PAR_WORDS; i++)
         if (bus_addr == OFS_PAR + 7'(4 * i)) bus_rdata = par_words[i*32 +: 32];
      for (int i = 0; i < IDX_WORDS; i++)
         if (bus_addr == OFS_IDX + 7'(4 * i)) bus_rdata = idx_words[i*32 +: 32];
   end

   assign irq        = |(stat_q[IE_W-1:0] & ie_q);
   assign eng_en     = ctrl_q[CB_EN];
   assign eng_init   = ctrl_q[CB_INIT];
   assign eng_strong = ctrl_q[CB_STRONG];
   assign eng_enc    = ctrl_q[CB_ENC];
endmodule

// File: rtl/ecc_regfront_chk.sv
module ecc_regfront_chk
   import ecc_regfront_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [6:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic [3:0]       ctrl_q,
   input logic             eng_init,
   input logic             eng_en,
   input logic             eng_byte_vld,
   input logic [7:0]       eng_byte,
   input logic [31:0]      stat_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             eng_res_vld,
   input logic             eng_uncor
);
   // R1
   ctrl_alias_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |->
         ($past(bus_wr) && ($past(bus_addr) == OFS_CSET || $past(bus_addr) == OFS_CCLR))
         || $past(ctrl_q[CB_INIT]));

   // R2
   init_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_init && !(bus_wr && bus_addr == OFS_CSET && bus_wdata[CB_INIT])) |=> !eng_init);

   // R4
   byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_byte_vld |-> ($past(eng_en) && !$past(eng_init)));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

   // R6
   all_ff_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[SB_AFF]) |-> (eng_byte_vld && eng_byte == 8'hFF));

   // R8
   uncor_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_res_vld && eng_uncor) |=> stat_q[SB_UNC]);
endmodule

bind ecc_regfront ecc_regfront_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .eng_init(eng_init),
   .eng_en(eng_en), .eng_byte_vld(eng_byte_vld), .eng_byte(eng_byte),
   .stat_q(stat_q), .cnt_q(byte_cnt), .eng_res_vld(eng_res_vld),
   .eng_uncor(eng_uncor)
);

// File: tb/tb_ecc_regfront.sv
`timescale 1ns/1ps
module tb_ecc_regfront;
   import ecc_regfront_pkg::*;

   localparam int PB = 13;
   localparam int IW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [6:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic irq, eng_en, eng_init, eng_strong, eng_enc, eng_byte_vld;
   logic [7:0] eng_byte;
   logic eng_res_vld = 1'b0, eng_uncor = 1'b0;
   logic [3:0] eng_err_cnt = '0;
   logic [6:0] eng_err_tot = '0;
   logic [PB*8-1:0] eng_parity = '0;
   logic [IW*32-1:0] eng_err_idx = '0;

   int checks = 0, errors = 0;

   // reference model state
   logic [3:0]  m_ctrl = '0;
   logic [5:0]  m_ie = '0;
   logic [31:0] m_stat = '0;
   int          m_enc = 0, m_dec = 0, m_n = 0;
   bit          m_aff = 1, m_a00 = 1, m_acc = 0;
   logic [7:0]  m_par [PB];
   logic [31:0] m_idx [IW];

   always #2 clk = ~clk;

   ecc_regfront dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .eng_en(eng_en), .eng_init(eng_init), .eng_strong(eng_strong),
      .eng_enc(eng_enc), .eng_byte_vld(eng_byte_vld), .eng_byte(eng_byte),
      .eng_res_vld(eng_res_vld), .eng_uncor(eng_uncor),
      .eng_err_cnt(eng_err_cnt), .eng_err_tot(eng_err_tot),
      .eng_parity(eng_parity), .eng_err_idx(eng_err_idx)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [6:0] a);
      logic [31:0] r = '0;
      if (a == OFS_CTRL) r = {28'd0, m_ctrl};
      else if (a == OFS_CNT) r = (32'(m_dec) << 16) | 32'(m_enc);
      else if (a == OFS_STAT) r = m_stat;
      else if (a == OFS_IE) r = {26'd0, m_ie};
      for (int w = 0; w < (PB + 3) / 4; w++)
         if (a == OFS_PAR + 7'(4 * w))
            for (int b = 0; b < 4; b++)
               if (w * 4 + b < PB) r[8*b +: 8] = m_par[w*4+b];
      for (int w = 0; w < IW; w++)
         if (a == OFS_IDX + 7'(4 * w)) r = m_idx[w];
      return r;
   endfunction

   task automatic m_write(logic [6:0] a, logic [31:0] d);
      int tgt;
      m_acc = 0;
      if (a == OFS_CSET) begin
         m_ctrl = m_ctrl | d[3:0];
         if (d[1]) begin m_n = 0; m_aff = 1; m_a00 = 1; end
         m_ctrl[1] = 1'b0;
      end else if (a == OFS_CCLR) m_ctrl = m_ctrl & ~d[3:0];
      else if (a == OFS_CNT) begin m_enc = int'(d[9:0]); m_dec = int'(d[25:16]); end
      else if (a == OFS_STAT) m_stat = m_stat & ~d;
      else if (a == OFS_IESET) m_ie = m_ie | d[5:0];
      else if (a == OFS_IECLR) m_ie = m_ie & ~d[5:0];
      else if (a == OFS_DATA) begin
         tgt = m_ctrl[3] ? m_enc : m_dec;
         if (m_ctrl[0] && m_n < tgt) begin
            m_acc = 1;
            m_aff = m_aff && (d[7:0] == 8'hFF);
            m_a00 = m_a00 && (d[7:0] == 8'h00);
            m_n++;
            if (m_n == tgt) begin
               m_stat |= m_ctrl[3] ? 32'h4 : 32'h8;
               if (m_aff) m_stat |= 32'h10;
               if (m_a00) m_stat |= 32'h20;
            end
         end
      end
   endtask

   task automatic wr(logic [6:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      m_write(a, d);
      if (a == OFS_DATA) begin
         check("R4 byte strobe", {31'd0, eng_byte_vld}, {31'd0, m_acc});
         if (m_acc) check("R4 byte value", {24'd0, eng_byte}, {24'd0, d[7:0]});
      end
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(logic [6:0] a, string tag);
      @(negedge clk); bus_addr = a; #1;
      check(tag, bus_rdata, m_read(a));
   endtask

   task automatic init_blk();
      wr(OFS_CSET, 32'h2);
   endtask

   task automatic feed(int n, logic [7:0] base, int step);
      for (int i = 0; i < n; i++) wr(OFS_DATA, 32'(base + 8'(i * step)));
   endtask

   task automatic eng_result(bit unc, logic [3:0] ec, logic [6:0] tot, logic [7:0] pb);
      @(negedge clk);
      eng_res_vld = 1'b1; eng_uncor = unc; eng_err_cnt = ec; eng_err_tot = tot;
      for (int i = 0; i < PB; i++) eng_parity[8*i +: 8] = pb + 8'(i);
      for (int w = 0; w < IW; w++) eng_err_idx[32*w +: 32] = {8'hA0, 8'(w), pb, 8'(w * 3)};
      @(posedge clk); #1;
      m_stat |= {ec, 5'd0, tot, 14'd0, unc, unc || (ec != 0)};
      for (int i = 0; i < PB; i++) m_par[i] = pb + 8'(i);
      for (int w = 0; w < IW; w++) m_idx[w] = {8'hA0, 8'(w), pb, 8'(w * 3)};
      @(negedge clk); eng_res_vld = 1'b0;
   endtask

   // per-clock comparison of outputs against the model (R10, R1)
   always @(negedge clk) if (rst_n) begin
      check("R10 irq", {31'd0, irq}, {31'd0, |(m_stat[5:0] & m_ie)});
      check("R1 ctrl outputs", {28'd0, eng_enc, eng_strong, 1'b0, eng_en},
            {28'd0, m_ctrl[3], m_ctrl[2], 1'b0, m_ctrl[0]});
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < PB; i++) m_par[i] = '0;
      for (int w = 0; w < IW; w++) m_idx[w] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // reset state
      rd(OFS_CTRL, "R1 reset ctrl");
      rd(OFS_CNT, "R3 reset count");
      rd(OFS_STAT, "R7 reset status");
      rd(OFS_IE, "R10 reset enable");

      // R1 set/clear aliases, direct write ignored
      wr(OFS_CSET, 32'h5);  rd(OFS_CTRL, "R1 set alias");
      wr(OFS_CTRL, 32'hF);  rd(OFS_CTRL, "R1 direct write ignored");
      wr(OFS_CCLR, 32'h4);  rd(OFS_CTRL, "R1 clear alias");
      wr(OFS_CSET, 32'h8);  rd(OFS_CTRL, "R1 encode select");

      // R3 field masking
      wr(OFS_CNT, 32'hFFFF_FFFF); rd(OFS_CNT, "R3 count mask");
      wr(OFS_CNT, 32'h0006_0004); rd(OFS_CNT, "R3 count fields");

      // R2 init pulse and self clear
      @(negedge clk); bus_wr = 1'b1; bus_addr = OFS_CSET; bus_wdata = 32'h2;
      @(posedge clk); #1;
      check("R2 init pulse high", {31'd0, eng_init}, 32'd1);
      m_write(OFS_CSET, 32'h2);
      @(negedge clk); bus_wr = 1'b0;
      @(posedge clk); #1;
      check("R2 init self-clear", {31'd0, eng_init}, 32'd0);
      rd(OFS_CTRL, "R2 init reads zero");

      // R5 encode completion, overrun ignored
      feed(4, 8'h11, 17);
      rd(OFS_STAT, "R5 encode done");
      wr(OFS_DATA, 32'h55);
      rd(OFS_STAT, "R5 overrun ignored");

      // R10 enable gating of irq
      wr(OFS_IESET, 32'h4);
      wr(OFS_IECLR, 32'h4);
      wr(OFS_IESET, 32'h3C);
      rd(OFS_IE, "R10 enable set/clear");

      // R7 clear
      wr(OFS_STAT, 32'h4); rd(OFS_STAT, "R7 clear done bit");

      // R4 disabled engine ignores data
      wr(OFS_CCLR, 32'h1); init_blk();
      feed(3, 8'h01, 1);
      wr(OFS_CSET, 32'h1);

      // R6 all-FF decode block
      wr(OFS_CCLR, 32'h8); init_blk();
      feed(6, 8'hFF, 0);
      rd(OFS_STAT, "R6 all ff");

      // R6 all-zero decode block
      init_blk();
      feed(6, 8'h00, 0);
      rd(OFS_STAT, "R6 all zero");

      // R7 partial clear
      wr(OFS_STAT, 32'h10); rd(OFS_STAT, "R7 partial clear");
      wr(OFS_STAT, m_stat); rd(OFS_STAT, "R7 write back clears all");

      // R6 mixed block leaves blank flags clear
      init_blk();
      feed(5, 8'hFF, 0); wr(OFS_DATA, 32'h7E);
      rd(OFS_STAT, "R6 mixed block");
      wr(OFS_STAT, 32'hFFFF_FFFF);

      // R8, R9, R11 engine results
      eng_result(1'b0, 4'd3, 7'd5, 8'h01);
      rd(OFS_STAT, "R8 correctable result");
      for (int w = 0; w < 4; w++) rd(OFS_PAR + 7'(4 * w), "R9 parity word");
      for (int w = 0; w < IW; w++) rd(OFS_IDX + 7'(4 * w), "R11 index word");
      eng_result(1'b1, 4'd0, 7'd9, 8'h40);
      rd(OFS_STAT, "R8 uncorrectable result");
      rd(OFS_PAR + 7'd12, "R9 partial word");
      wr(OFS_STAT, 32'hFFFF_FFFF);

      // R5 zero count accepts nothing
      wr(OFS_CNT, 32'h0); init_blk();
      feed(2, 8'h33, 1);
      rd(OFS_STAT, "R5 zero count");

      repeat (4) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule